// File: doc/BRIEF.md
# Paged Instruction Fetch Unit

This block is the fetch front end of a small RISC core whose instructions are a fixed 13 bits wide. It holds a 17-bit program counter made of a 7-bit page number and a 10-bit offset within that page. It reads program memory through two byte-wide read lanes. The even lane supplies the low byte of each instruction and the odd lane supplies the high byte. The two bytes form a 16-bit word, and the instruction is the low 13 bits of that word.

The pipeline has two stages. While one instruction sits in the execute register, the next one is already being fetched at the program counter. When the executing instruction is a taken jump or call, the decoder raises a request and presents a target offset. The page for the target comes from a separate page register. The unit loads page and offset into the counter. It also discards the instruction that was prefetched on the sequential path by placing a no-operation in the execute register for one cycle.

Top module: `pif_fetch_unit`

## Requirements
- R1: While reset is asserted, `fetch_pc` is 0 (page 0, offset 0), `instr` holds the no-operation code 13'h0000 and `instr_valid` is low.
- R2: On an edge with no taken redirect, `instr` takes bits 12:0 of the 16-bit word formed from the odd-address byte (bits 15:8) and the even-address byte (bits 7:0) read at the current `fetch_pc`. The top three bits of that word are dropped.
- R3: On an edge with no taken redirect, the 10-bit offset of `fetch_pc` increases by one, wrapping from 1023 to 0. The 7-bit page is left unchanged.
- R4: A taken redirect loads `fetch_pc` with `page_in` in bits 16:10 and `tgt_off` in bits 9:0 on the same edge.
- R5: In the cycle after a taken redirect, `instr_valid` is low and `instr` is the no-operation code.
- R6: Two cycles after a taken redirect, `instr_valid` is high and `instr` is the instruction stored at the target.
- R7: A jump or call request is taken only while `instr_valid` is high. A request made during a bubble or directly after reset has no effect on `fetch_pc` or on the pipeline.
- R8: `call_req` redirects exactly as `jmp_req` does. Raising both at once acts as a single redirect.
- R9: `mem_lo_addr` is `{fetch_pc, 1'b0}` and `mem_hi_addr` is `{fetch_pc, 1'b1}`. Both follow the counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jmp_req | input | 1 | Jump request from the decoder for the executing instruction |
| call_req | input | 1 | Call request from the decoder for the executing instruction |
| tgt_off | input | 10 | Target offset within the page |
| page_in | input | 7 | Current working page from the page register |
| mem_lo_addr | output | 18 | Byte address of the even (low) byte |
| mem_lo_data | input | 8 | Byte read at `mem_lo_addr`, combinational |
| mem_hi_addr | output | 18 | Byte address of the odd (high) byte |
| mem_hi_data | input | 8 | Byte read at `mem_hi_addr`, combinational |
| fetch_pc | output | 17 | Program counter of the instruction being fetched |
| instr | output | 13 | Instruction in the execute stage |
| instr_valid | output | 1 | High when `instr` is a real instruction |

## Verification
The memory addresses follow `fetch_pc` within the same cycle. `fetch_pc`, `instr` and `instr_valid` each change one edge after the inputs that cause them. The target instruction therefore arrives two edges after a taken request.

The bench drives inputs at the falling edge and advances its reference model once per rising edge. It compares every output at the next falling edge, so each result is sampled exactly one register after its cause. For a redirect, the bubble is checked on the first falling edge and the target word on the second. The program memory is a computed byte function, so every instruction can be predicted at any address.

// File: rtl/pif_pkg.sv
package pif_pkg;

   // Execute-stage slot state
   typedef enum logic {
      SLOT_BUBBLE = 1'b0,
      SLOT_LIVE   = 1'b1
   } slot_e;

   // Decoded redirect kind presented by the decoder
   typedef enum logic [1:0] {
      RDR_NONE = 2'b00,
      RDR_JUMP = 2'b01,
      RDR_CALL = 2'b10,
      RDR_BOTH = 2'b11
   } redirect_e;

   function automatic logic redirect_taken(input redirect_e kind, input slot_e slot);
      return (kind != RDR_NONE) && (slot == SLOT_LIVE);
   endfunction

endpackage

// File: rtl/pif_pc_seq.sv
module pif_pc_seq #(
   parameter int PAGE_W       = 7,
   parameter int OFF_W        = 10,
   parameter bit WRAP_IN_PAGE = 1'b1,
   localparam int PC_W        = PAGE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [PAGE_W-1:0] tgt_page,
   input  logic [OFF_W-1:0]  tgt_off,
   output logic [PC_W-1:0]   pc
);

   if (PAGE_W < 1) begin : g_bad_page
      $error("pif_pc_seq: PAGE_W must be at least 1");
   end
   if (OFF_W < 2) begin : g_bad_off
      $error("pif_pc_seq: OFF_W must be at least 2");
   end

   logic [PAGE_W-1:0] cur_page;
   logic [OFF_W-1:0]  cur_off;
   logic [PC_W-1:0]   seq_pc;

   assign cur_page = pc[PC_W-1:OFF_W];
   assign cur_off  = pc[OFF_W-1:0];

   if (WRAP_IN_PAGE) begin : g_wrap
      logic [OFF_W-1:0] off_inc;
      assign off_inc = cur_off + {{(OFF_W-1){1'b0}}, 1'b1};
      assign seq_pc  = {cur_page, off_inc};
   end else begin : g_carry
      assign seq_pc  = pc + {{(PC_W-1){1'b0}}, 1'b1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (redirect) begin
         pc <= {tgt_page, tgt_off};
      end else begin
         pc <= seq_pc;
      end
   end

   if (WRAP_IN_PAGE) begin : g_wrap_chk
      // R3: sequential step moves the offset only, page held
      p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !redirect |=> (pc[PC_W-1:OFF_W] == $past(pc[PC_W-1:OFF_W])) &&
                       (pc[OFF_W-1:0] == OFF_W'($past(pc[OFF_W-1:0]) + 1'b1)))
         else $error("p_seq_step_r3 failed");
   end

endmodule

// File: rtl/pif_byte_pair.sv
module pif_byte_pair #(
   parameter int PC_W    = 17,
   parameter int BYTE_W  = 8,
   parameter int INSTR_W = 13,
   localparam int WORD_W = 2 * BYTE_W,
   localparam int ADDR_W = PC_W + 1
) (
   input  logic [PC_W-1:0]    pc,
   output logic [ADDR_W-1:0]  lo_addr,
   output logic [ADDR_W-1:0]  hi_addr,
   input  logic [BYTE_W-1:0]  lo_data,
   input  logic [BYTE_W-1:0]  hi_data,
   output logic [INSTR_W-1:0] word_instr
);

   if (INSTR_W > WORD_W) begin : g_bad_instr
      $error("pif_byte_pair: INSTR_W exceeds two bytes");
   end
   if (INSTR_W <= BYTE_W) begin : g_bad_small
      $error("pif_byte_pair: INSTR_W must need both bytes");
   end

   logic [WORD_W-1:0] word;

   assign lo_addr = {pc, 1'b0};
   assign hi_addr = {pc, 1'b1};
   assign word    = {hi_data, lo_data};

   if (INSTR_W == WORD_W) begin : g_full
      assign word_instr = word;
   end else begin : g_trim
      logic [WORD_W-INSTR_W-1:0] unused_top;
      assign unused_top = word[WORD_W-1:INSTR_W];
      assign word_instr = word[INSTR_W-1:0];
   end

   // R9: both lanes address the same word slot
   always_comb begin
      a_pair_r9: assert (hi_addr[ADDR_W-1:1] == lo_addr[ADDR_W-1:1])
         else $error("a_pair_r9 failed");
   end

endmodule

// File: rtl/pif_exec_stage.sv
module pif_exec_stage
   import pif_pkg::*;
#(
   parameter int             INSTR_W  = 13,
   parameter logic [31:0]    NOP_CODE = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               squash,
   input  logic [INSTR_W-1:0] fetched,
   output logic [INSTR_W-1:0] instr,
   output slot_e              slot
);

   localparam logic [INSTR_W-1:0] NOP = NOP_CODE[INSTR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr <= NOP;
         slot  <= SLOT_BUBBLE;
      end else if (squash) begin
         instr <= NOP;
         slot  <= SLOT_BUBBLE;
      end else begin
         instr <= fetched;
         slot  <= SLOT_LIVE;
      end
   end

   // R5: the cycle after a squash is a bubble holding the no-operation
   p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (slot == SLOT_BUBBLE) && (instr == NOP))
      else $error("p_bubble_r5 failed");

   // R6: the target instruction is live two edges after the squash
   p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> ##1 (slot == SLOT_LIVE))
      else $error("p_refill_r6 failed");

endmodule

// File: rtl/pif_fetch_unit.sv
module pif_fetch_unit
   import pif_pkg::*;
#(
   parameter int          PAGE_W       = 7,
   parameter int          OFF_W        = 10,
   parameter int          BYTE_W       = 8,
   parameter int          INSTR_W      = 13,
   parameter logic [31:0] NOP_CODE     = 32'h0,
   parameter bit          WRAP_IN_PAGE = 1'b1,
   localparam int         PC_W         = PAGE_W + OFF_W,
   localparam int         ADDR_W       = PC_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               jmp_req,
   input  logic               call_req,
   input  logic [OFF_W-1:0]   tgt_off,
   input  logic [PAGE_W-1:0]  page_in,
   output logic [ADDR_W-1:0]  mem_lo_addr,
   input  logic [BYTE_W-1:0]  mem_lo_data,
   output logic [ADDR_W-1:0]  mem_hi_addr,
   input  logic [BYTE_W-1:0]  mem_hi_data,
   output logic [PC_W-1:0]    fetch_pc,
   output logic [INSTR_W-1:0] instr,
   output logic               instr_valid
);

   redirect_e          kind;
   slot_e              slot;
   logic               redirect;
   logic [INSTR_W-1:0] word_instr;

   assign kind        = redirect_e'({call_req, jmp_req});
   assign redirect    = redirect_taken(kind, slot);
   assign instr_valid = (slot == SLOT_LIVE);

   pif_pc_seq #(
      .PAGE_W       (PAGE_W),
      .OFF_W        (OFF_W),
      .WRAP_IN_PAGE (WRAP_IN_PAGE)
   ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .redirect (redirect),
      .tgt_page (page_in),
      .tgt_off  (tgt_off),
      .pc       (fetch_pc)
   );

   pif_byte_pair #(
      .PC_W    (PC_W),
      .BYTE_W  (BYTE_W),
      .INSTR_W (INSTR_W)
   ) u_pair (
      .pc         (fetch_pc),
      .lo_addr    (mem_lo_addr),
      .hi_addr    (mem_hi_addr),
      .lo_data    (mem_lo_data),
      .hi_data    (mem_hi_data),
      .word_instr (word_instr)
   );

   pif_exec_stage #(
      .INSTR_W  (INSTR_W),
      .NOP_CODE (NOP_CODE)
   ) u_exec (
      .clk     (clk),
      .rst_n   (rst_n),
      .squash  (redirect),
      .fetched (word_instr),
      .instr   (instr),
      .slot    (slot)
   );

   // R4: a taken redirect loads page register and offset into the counter
   p_target_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> fetch_pc == {$past(page_in), $past(tgt_off)})
      else $error("p_target_load_r4 failed");

   // R2: the executing instruction is the word fetched on the prior cycle
   p_word_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> instr == $past(word_instr))
      else $error("p_word_pass_r2 failed");

   // R7: requests during a bubble never extend it
   p_bubble_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> instr_valid)
      else $error("p_bubble_ignores_r7 failed");

   // R8: a simultaneous jump and call redirects once, to the given target
   p_dual_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_req && call_req && instr_valid) |=>
         !instr_valid && (fetch_pc == {$past(page_in), $past(tgt_off)}))
      else $error("p_dual_req_r8 failed");

endmodule

// File: tb/pif_fetch_unit_test.sv
`timescale 1ns/1ps
module pif_fetch_unit_test;

   localparam logic [12:0] NOP = 13'h0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        jmp_req, call_req;
   logic [9:0]  tgt_off;
   logic [6:0]  page_in;
   logic [17:0] mem_lo_addr, mem_hi_addr;
   logic [7:0]  mem_lo_data, mem_hi_data;
   logic [16:0] fetch_pc;
   logic [12:0] instr;
   logic        instr_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [16:0] exp_pc;
   logic [12:0] exp_instr;
   logic        exp_valid;

   always #2 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [17:0] a);
      logic [31:0] t;
      t = ({14'd0, a} * 32'd29) ^ ({14'd0, a} >> 7) ^ 32'h0000_00A5;
      return t[7:0];
   endfunction

   function automatic logic [12:0] word_at(input logic [16:0] pc);
      logic [15:0] w;
      w = {mem_byte({pc, 1'b1}), mem_byte({pc, 1'b0})};
      return w[12:0];
   endfunction

   function automatic logic [16:0] seq_next(input logic [16:0] pc);
      return {pc[16:10], pc[9:0] + 10'd1};
   endfunction

   assign mem_lo_data = mem_byte(mem_lo_addr);
   assign mem_hi_data = mem_byte(mem_hi_addr);

   pif_fetch_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .jmp_req     (jmp_req),
      .call_req    (call_req),
      .tgt_off     (tgt_off),
      .page_in     (page_in),
      .mem_lo_addr (mem_lo_addr),
      .mem_lo_data (mem_lo_data),
      .mem_hi_addr (mem_hi_addr),
      .mem_hi_data (mem_hi_data),
      .fetch_pc    (fetch_pc),
      .instr       (instr),
      .instr_valid (instr_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_reset();
      chk("R1 pc",    {15'd0, fetch_pc},    32'd0);
      chk("R1 instr", {19'd0, instr},       {19'd0, NOP});
      chk("R1 valid", {31'd0, instr_valid}, 32'd0);
      exp_pc    = '0;
      exp_instr = NOP;
      exp_valid = 1'b0;
   endtask

   // Called at a falling edge: drive, advance model, check at next falling edge
   task automatic step(input logic j, input logic c, input logic [9:0] off, input logic [6:0] pg);
      logic  take, req, wrap;
      string pc_tag, in_tag, v_tag;
      jmp_req  = j;
      call_req = c;
      tgt_off  = off;
      page_in  = pg;
      chk("R9 lo addr", {14'd0, mem_lo_addr}, {14'd0, exp_pc, 1'b0});
      chk("R9 hi addr", {14'd0, mem_hi_addr}, {14'd0, exp_pc, 1'b1});
      req  = j | c;
      take = req & exp_valid;
      wrap = (exp_pc[9:0] == 10'h3FF);
      if (take) begin
         pc_tag    = (c && !j) ? "R8 call target" : "R4 target";
         in_tag    = "R5 nop";
         v_tag     = "R5 bubble";
         exp_instr = NOP;
         exp_valid = 1'b0;
         exp_pc    = {pg, off};
      end else begin
         pc_tag    = req ? "R7 ignored request" : (wrap ? "R3 wrap" : "R3 step");
         in_tag    = exp_valid ? "R2 word" : "R6 target word";
         v_tag     = exp_valid ? "R2 valid" : "R6 refill";
         exp_instr = word_at(exp_pc);
         exp_valid = 1'b1;
         exp_pc    = seq_next(exp_pc);
      end
      @(posedge clk);
      @(negedge clk);
      chk(pc_tag, {15'd0, fetch_pc},    {15'd0, exp_pc});
      chk(in_tag, {19'd0, instr},       {19'd0, exp_instr});
      chk(v_tag,  {31'd0, instr_valid}, {31'd0, exp_valid});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 10'd0, 7'd0);
   endtask

   initial begin
      rst_n = 1'b0; jmp_req = 1'b0; call_req = 1'b0; tgt_off = '0; page_in = '0;
      repeat (3) @(negedge clk);
      // R1: reset state, with a request held to show it is ignored
      jmp_req = 1'b1; tgt_off = 10'd55; page_in = 7'd9;
      @(negedge clk);
      check_reset();
      jmp_req = 1'b0;
      rst_n = 1'b1;
      // R7: request on the first cycle after reset is ignored
      step(1'b1, 1'b0, 10'd77, 7'd5);
      idle(5);
      // R3 wrap: jump near page end, then run across the boundary
      step(1'b1, 1'b0, 10'd1022, 7'd3);
      idle(4);
      // R7: jump, then a second jump during the bubble
      step(1'b1, 1'b0, 10'd12, 7'd100);
      step(1'b1, 1'b0, 10'd500, 7'd1);
      idle(2);
      // R8: call alone, then both requests together
      step(1'b0, 1'b1, 10'd300, 7'd127);
      idle(2);
      step(1'b1, 1'b1, 10'd1023, 7'd64);
      idle(3);
      // back-to-back redirects on every live slot
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 10'(i * 97), 7'(i * 21));
      // R1: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      idle(3);
      // constrained random traffic with a fixed seed
      void'($urandom(32'd2024));
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] r;
         r = 8'($urandom_range(0, 99));
         step(r < 8'd15, (r >= 8'd15) && (r < 8'd25) || (r > 8'd96),
              10'($urandom_range(0, 1023)), 7'($urandom_range(0, 127)));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule